// File: doc/BRIEF.md
# Packed Instruction Register Sequencer

This block sits between instruction fetch and decode in a small RISC pipeline. Each cycle it may accept one 32-bit fetched word. It then hands decode a stream of 32-bit instructions, one per cycle. A fetched word takes one of three forms. An ordinary word goes through untouched. A loosely packed word is an ordinary instruction whose low five bits name one extra entry of an on-chip instruction register file. A packed word names up to five entries of that file, which issue in order.

Each entry of the instruction register file holds the upper half of an instruction, a 16-bit default immediate in its lower half, and a branch flag. The file has several windows, and a window register picks which one is read. In a packed word, selected slots can receive a 5-bit parameter in place of the default immediate. For an ordinary entry, the parameter indexes a shared 32-entry immediate table. For a branch entry, the parameter is used directly as a signed displacement. While a packed word still has work left, the block raises a fetch stall. It signals readiness for the next word in the cycle the final item issues. A taken branch reported by the pipeline drops the slots that remain. The tables and the window register are loaded through simple write ports.

Top module: `packedSeqTop`

## Requirements
- R1: After a synchronous active-low reset, `issueValid`, `fetchStall` and `nextReady` are low, and window 0 is selected.
- R2: A word is accepted at a rising edge where `fetchValid` is high and `fetchStall` is low. An accepted word whose opcode (bits 31:26) is below 0x30 appears unchanged on `issueWord` with `issueValid` high for exactly one cycle, in the cycle after acceptance.
- R3: Opcodes 0x3C to 0x3F are packed. The slot fields are A = bits 25:21, B = 20:16, C = 15:11, P = 9:5 and Q = 4:0. Slots 1 to 3 take A, B and C. 0x3C adds slots 4 and 5 from P and Q. 0x3D puts parameter P on slot 1 and Q on slot 3. 0x3E puts P on slot 2 and Q on slot 3. 0x3F adds slot 4 from P and puts parameter Q on slot 2. Live slots issue in slot order, one per cycle, starting the cycle after acceptance.
- R4: A slot whose index is 0 is skipped. It takes no issue cycle.
- R5: A parameterized slot whose entry is not a branch issues the entry's bits 31:16 above the immediate-table value at the parameter's index.
- R6: A parameterized slot whose entry has the branch flag issues the entry's bits 31:16 above the parameter sign-extended to 16 bits.
- R7: A slot without a parameter issues the stored entry unchanged. Its low 16 bits are the default immediate.
- R8: Opcodes 0x30 to 0x3B are loosely packed. The word issues unchanged, and in the next cycle entry bits 4:0 of the word issues with its default immediate. If that index is 0, only the word issues.
- R9: Every entry read uses address {window register, slot index}. The window register is loaded by `winWrEn`.
- R10: `fetchStall` is high in every issue cycle except the one issuing the last remaining item. `nextReady` is high in exactly that last cycle. A new word may be accepted at the end of that cycle, so words can run back to back.
- R11: When `branchTaken` is high in an issue cycle, that item is the last of its word. `fetchStall` falls and `nextReady` rises in the same cycle, and the remaining slots never issue.
- R12: Bit 10 of a packed word has no effect on what issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| fetchValid | input | 1 | A fetched word is offered |
| fetchWord | input | 32 | Fetched word |
| branchTaken | input | 1 | The item issued this cycle is a taken branch |
| fetchStall | output | 1 | Hold the fetched word; more items remain |
| nextReady | output | 1 | Last item of the current word issues now |
| issueValid | output | 1 | `issueWord` carries an instruction |
| issueWord | output | 32 | Instruction to decode |
| irfWrEn | input | 1 | Write an instruction register file entry |
| irfWrAddr | input | 7 | Entry address {window, index} |
| irfWrInst | input | 32 | Entry instruction; low half is the default immediate |
| irfWrBranch | input | 1 | Entry is a branch |
| immWrEn | input | 1 | Write an immediate table entry |
| immWrAddr | input | 5 | Immediate table address |
| immWrData | input | 16 | Immediate value |
| winWrEn | input | 1 | Load the window register |
| winWrData | input | 2 | New window number |

## Verification
The hardest case to reach is a taken-branch flush in the middle of a packed word. The flag has to arrive in exactly the cycle the branch slot issues, and the bench has to show that the later slots never appear. The bench drives `branchTaken` right after the accepting edge, while the first slot is on the output. It expects only that slot on its scoreboard, so any leftover slot shows up as an unexpected item. Parameter substitution is forced through both paths by placing parameters on a branch entry and on an ordinary entry within the same word.

// File: rtl/pseqPkg.sv
package pseqPkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 5;
  localparam int SLOTS  = 5;
  localparam int IMM_W  = 16;
  localparam int SEL_W  = $clog2(SLOTS);

  localparam logic [5:0] OP_FIVE    = 6'h3C;
  localparam logic [5:0] OP_PAR13   = 6'h3D;
  localparam logic [5:0] OP_PAR23   = 6'h3E;
  localparam logic [5:0] OP_FOUR_P2 = 6'h3F;

  typedef struct packed {
    logic             issueValid;
    logic             selPass;
    logic             loadPass;
    logic [IDX_W-1:0] slotIdx;
    logic             useParam;
    logic [IDX_W-1:0] paramVal;
  } seqStrobe_t;
endpackage

// File: rtl/seqControl.sv
module seqControl
  import pseqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fetchValid,
  input  logic [30:0] fieldWord,
  input  logic        branchTaken,
  output logic        fetchStall,
  output logic        nextReady,
  output seqStrobe_t  strobe
);
  logic [5:0] opcode;
  logic       isPacked;
  logic [IDX_W-1:0] dIdx [SLOTS];
  logic [IDX_W-1:0] dPar [SLOTS];
  logic [SLOTS-1:0] dUse;
  logic [SLOTS-1:0] dPend;
  logic             dPass;

  logic [IDX_W-1:0] idxQ [SLOTS];
  logic [IDX_W-1:0] parQ [SLOTS];
  logic [SLOTS-1:0] useQ;
  logic [SLOTS-1:0] pendQ;
  logic             passQ;
  logic [SEL_W-1:0] curSel;
  logic [3:0]       remaining;
  logic             busy, lastItem, accept;

  assign opcode   = fieldWord[30:25];
  assign isPacked = (opcode[5:2] == 4'b1111);

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      dIdx[i] = '0;
      dPar[i] = '0;
    end
    dUse  = '0;
    dPass = 1'b0;
    if (isPacked) begin
      dIdx[0] = fieldWord[24:20];
      dIdx[1] = fieldWord[19:15];
      dIdx[2] = fieldWord[14:10];
    end
    unique case (opcode)
      OP_FIVE: begin
        dIdx[3] = fieldWord[9:5];
        dIdx[4] = fieldWord[4:0];
      end
      OP_PAR13: begin
        dUse[0] = 1'b1; dPar[0] = fieldWord[9:5];
        dUse[2] = 1'b1; dPar[2] = fieldWord[4:0];
      end
      OP_PAR23: begin
        dUse[1] = 1'b1; dPar[1] = fieldWord[9:5];
        dUse[2] = 1'b1; dPar[2] = fieldWord[4:0];
      end
      OP_FOUR_P2: begin
        dIdx[3] = fieldWord[9:5];
        dUse[1] = 1'b1; dPar[1] = fieldWord[4:0];
      end
      default: begin
        dPass = 1'b1;
        if (opcode[5:4] == 2'b11) dIdx[0] = fieldWord[4:0];
      end
    endcase
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_pend
    assign dPend[g] = (dIdx[g] != '0);
  end

  always_comb begin
    curSel = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (pendQ[i]) curSel = SEL_W'(i);
    end
  end

  assign remaining  = 4'($countones({passQ, pendQ}));
  assign busy       = (remaining != 4'd0);
  assign lastItem   = (remaining == 4'd1);
  assign fetchStall = busy && !lastItem && !branchTaken;
  assign nextReady  = busy && (lastItem || branchTaken);
  assign accept     = fetchValid && !fetchStall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      passQ <= 1'b0;
    end else if (accept) begin
      pendQ <= dPend;
      passQ <= dPass;
    end else if (busy) begin
      if (branchTaken) begin
        pendQ <= '0;
        passQ <= 1'b0;
      end else if (passQ) begin
        passQ <= 1'b0;
      end else begin
        pendQ[curSel] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int i = 0; i < SLOTS; i++) begin
        idxQ[i] <= dIdx[i];
        parQ[i] <= dPar[i];
      end
      useQ <= dUse;
    end
  end

  always_comb begin
    strobe.issueValid = busy;
    strobe.selPass    = passQ;
    strobe.loadPass   = accept;
    strobe.slotIdx    = idxQ[curSel];
    strobe.useParam   = useQ[curSel];
    strobe.paramVal   = parQ[curSel];
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import pseqPkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int ADDR_W = WIN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] fetchWord,
  input  seqStrobe_t        strobe,
  input  logic              irfWrEn,
  input  logic [ADDR_W-1:0] irfWrAddr,
  input  logic [WORD_W-1:0] irfWrInst,
  input  logic              irfWrBranch,
  input  logic              immWrEn,
  input  logic [IDX_W-1:0]  immWrAddr,
  input  logic [IMM_W-1:0]  immWrData,
  input  logic              winWrEn,
  input  logic [WIN_W-1:0]  winWrData,
  output logic              issueValid,
  output logic [WORD_W-1:0] issueWord
);
  localparam int IRF_DEPTH = 1 << ADDR_W;
  localparam int IMM_DEPTH = 1 << IDX_W;

  logic [WORD_W:0]     irfMem [IRF_DEPTH];
  logic [IMM_W-1:0]    immMem [IMM_DEPTH];
  logic [WIN_W-1:0]    winQ;
  logic [WORD_W-1:0]   passWordQ;
  logic [WORD_W:0]     rdEntry;
  logic [IMM_W-1:0]    effImm;

  always_ff @(posedge clk) begin
    if (irfWrEn) irfMem[irfWrAddr] <= {irfWrBranch, irfWrInst};
    if (immWrEn) immMem[immWrAddr] <= immWrData;
    if (strobe.loadPass) passWordQ <= fetchWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        winQ <= '0;
    else if (winWrEn) winQ <= winWrData;
  end

  always_comb begin
    rdEntry = irfMem[{winQ, strobe.slotIdx}];
    if (!strobe.useParam)
      effImm = rdEntry[IMM_W-1:0];
    else if (rdEntry[WORD_W])
      effImm = {{(IMM_W - IDX_W){strobe.paramVal[IDX_W-1]}}, strobe.paramVal};
    else
      effImm = immMem[strobe.paramVal];
  end

  assign issueValid = strobe.issueValid;
  assign issueWord  = strobe.selPass ? passWordQ : {rdEntry[WORD_W-1:IMM_W], effImm};
endmodule

// File: rtl/packedSeqTop.sv
module packedSeqTop
  import pseqPkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int ADDR_W = WIN_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchValid,
  input  logic [WORD_W-1:0] fetchWord,
  input  logic              branchTaken,
  output logic              fetchStall,
  output logic              nextReady,
  output logic              issueValid,
  output logic [WORD_W-1:0] issueWord,
  input  logic              irfWrEn,
  input  logic [ADDR_W-1:0] irfWrAddr,
  input  logic [WORD_W-1:0] irfWrInst,
  input  logic              irfWrBranch,
  input  logic              immWrEn,
  input  logic [IDX_W-1:0]  immWrAddr,
  input  logic [IMM_W-1:0]  immWrData,
  input  logic              winWrEn,
  input  logic [WIN_W-1:0]  winWrData
);
  seqStrobe_t strobe;

  seqControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fetchValid (fetchValid),
    .fieldWord  ({fetchWord[31:11], fetchWord[9:0]}),
    .branchTaken(branchTaken),
    .fetchStall (fetchStall),
    .nextReady  (nextReady),
    .strobe     (strobe)
  );

  seqDatapath #(.NUM_WIN(NUM_WIN)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .fetchWord  (fetchWord),
    .strobe     (strobe),
    .irfWrEn    (irfWrEn),
    .irfWrAddr  (irfWrAddr),
    .irfWrInst  (irfWrInst),
    .irfWrBranch(irfWrBranch),
    .immWrEn    (immWrEn),
    .immWrAddr  (immWrAddr),
    .immWrData  (immWrData),
    .winWrEn    (winWrEn),
    .winWrData  (winWrData),
    .issueValid (issueValid),
    .issueWord  (issueWord)
  );
endmodule

// File: rtl/seqCheck.sv
module seqCheck (
  input logic clk,
  input logic rstN,
  input logic fetchValid,
  input logic branchTaken,
  input logic fetchStall,
  input logic nextReady,
  input logic issueValid
);
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (!issueValid && !fetchStall && !nextReady));

  p_stall_ready_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchStall && nextReady));

  p_stall_needs_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    fetchStall |-> issueValid);

  p_ready_needs_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    nextReady |-> issueValid);

  p_stall_keeps_issuing_r3: assert property (@(posedge clk) disable iff (!rstN)
    (fetchStall && !branchTaken) |=> issueValid);

  p_flush_drops_rest_r11: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && branchTaken && !fetchValid) |=> !issueValid);
endmodule

bind packedSeqTop seqCheck u_seqCheck (
  .clk        (clk),
  .rstN       (rstN),
  .fetchValid (fetchValid),
  .branchTaken(branchTaken),
  .fetchStall (fetchStall),
  .nextReady  (nextReady),
  .issueValid (issueValid)
);

// File: tb/packedSeqTop_bench.sv
module packedSeqTop_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchValid = 1'b0;
  logic [31:0] fetchWord = '0;
  logic        branchTaken = 1'b0;
  logic        fetchStall, nextReady, issueValid;
  logic [31:0] issueWord;
  logic        irfWrEn = 1'b0;
  logic [6:0]  irfWrAddr = '0;
  logic [31:0] irfWrInst = '0;
  logic        irfWrBranch = 1'b0;
  logic        immWrEn = 1'b0;
  logic [4:0]  immWrAddr = '0;
  logic [15:0] immWrData = '0;
  logic        winWrEn = 1'b0;
  logic [1:0]  winWrData = '0;

  int total = 0;
  int bad = 0;
  logic [32:0] mIrf [128];
  logic [15:0] mImm [32];
  logic [1:0]  mWin = 2'd0;
  logic [31:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  packedSeqTop u_packedSeqTop (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchWord(fetchWord),
    .branchTaken(branchTaken), .fetchStall(fetchStall), .nextReady(nextReady),
    .issueValid(issueValid), .issueWord(issueWord),
    .irfWrEn(irfWrEn), .irfWrAddr(irfWrAddr), .irfWrInst(irfWrInst),
    .irfWrBranch(irfWrBranch), .immWrEn(immWrEn), .immWrAddr(immWrAddr),
    .immWrData(immWrData), .winWrEn(winWrEn), .winWrData(winWrData)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
      input logic [4:0] b, input logic [4:0] c, input logic s,
      input logic [4:0] p, input logic [4:0] q);
    return {op, a, b, c, s, p, q};
  endfunction

  function automatic logic [31:0] slotOut(input logic [4:0] idx, input bit usePar,
                                          input logic [4:0] par);
    logic [32:0] e;
    e = mIrf[{mWin, idx}];
    if (!usePar) return e[31:0];
    if (e[32]) return {e[31:16], {11{par[4]}}, par};
    return {e[31:16], mImm[par]};
  endfunction

  task automatic pushExp(input logic [31:0] w, input string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
  endtask

  task automatic expectWord(input logic [31:0] w, input string tag);
    logic [4:0] ix [5];
    logic [4:0] pv [5];
    bit         up [5];
    logic [5:0] op;
    op = w[31:26];
    for (int i = 0; i < 5; i++) begin ix[i] = 0; pv[i] = 0; up[i] = 0; end
    if (op < 6'h30) begin
      pushExp(w, tag);
      return;
    end
    if (op < 6'h3C) begin
      pushExp(w, tag);
      if (w[4:0] != 0) pushExp(slotOut(w[4:0], 0, 0), tag);
      return;
    end
    ix[0] = w[25:21]; ix[1] = w[20:16]; ix[2] = w[15:11];
    case (op)
      6'h3C: begin ix[3] = w[9:5]; ix[4] = w[4:0]; end
      6'h3D: begin up[0] = 1; pv[0] = w[9:5]; up[2] = 1; pv[2] = w[4:0]; end
      6'h3E: begin up[1] = 1; pv[1] = w[9:5]; up[2] = 1; pv[2] = w[4:0]; end
      default: begin ix[3] = w[9:5]; up[1] = 1; pv[1] = w[4:0]; end
    endcase
    for (int i = 0; i < 5; i++)
      if (ix[i] != 0) pushExp(slotOut(ix[i], up[i], pv[i]), tag);
  endtask

  task automatic sendWord(input logic [31:0] w);
    bit acc;
    fetchValid = 1'b1;
    fetchWord  = w;
    do begin
      @(negedge clk);
      acc = !fetchStall;
      @(posedge clk);
      #1;
    end while (!acc);
    fetchValid = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (issueValid || expQ.size() != 0);
    @(posedge clk);
    #1;
  endtask

  task automatic writeIrf(input logic [6:0] a, input logic [31:0] v, input bit br);
    irfWrEn = 1; irfWrAddr = a; irfWrInst = v; irfWrBranch = br;
    @(posedge clk); #1;
    irfWrEn = 0;
    mIrf[a] = {br, v};
  endtask

  task automatic writeImm(input logic [4:0] a, input logic [15:0] v);
    immWrEn = 1; immWrAddr = a; immWrData = v;
    @(posedge clk); #1;
    immWrEn = 0;
    mImm[a] = v;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && issueValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "unexpected issue (R4/R11)", issueWord, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(issueWord === e, t, issueWord, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    @(negedge clk);
    check(!issueValid && !fetchStall && !nextReady, "R1 idle after reset",
          {29'd0, issueValid, fetchStall, nextReady}, 32'h0);
    @(posedge clk); #1;
    rstN = 1'b1;

    for (int i = 1; i < 10; i++)
      writeIrf(7'(i), 32'hA000_0000 | (i << 16) | (32'h0100 + i), i == 5);
    writeIrf(7'd0, 32'h0, 0);
    writeIrf({2'd2, 5'd1}, 32'hB222_0042, 0);
    writeIrf({2'd2, 5'd2}, 32'hB333_0077, 1);
    for (int k = 0; k < 32; k++) writeImm(5'(k), 16'h7000 + 16'(k * 3));

    // R2 plain pass, low bits nonzero must not add an extra issue
    expectWord(32'h1234_5678, "R2 pass-through");
    sendWord(32'h1234_5678);
    waitIdle();

    // R3/R7/R10 five-slot packed, window 0 from reset (R1)
    begin
      logic [31:0] w;
      w = mk(6'h3C, 1, 2, 3, 0, 4, 6);
      expectWord(w, "R3 R7 five slots default imm, window0 R1");
      sendWord(w);
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(fetchStall == (k < 4), "R10 stall while items remain",
              {31'd0, fetchStall}, {31'd0, k < 4});
        check(nextReady == (k == 4), "R10 ready on last item",
              {31'd0, nextReady}, {31'd0, k == 4});
      end
      waitIdle();
    end

    // R4 zero slots skipped
    expectWord(mk(6'h3C, 1, 0, 3, 0, 0, 2), "R4 nop slots skipped");
    sendWord(mk(6'h3C, 1, 0, 3, 0, 0, 2));
    waitIdle();

    // R5/R6 parameters on slots 1 and 3: ordinary entry and branch entry
    expectWord(mk(6'h3D, 2, 4, 5, 0, 7, 5'b11011), "R5 R6 params slots 1,3");
    sendWord(mk(6'h3D, 2, 4, 5, 0, 7, 5'b11011));
    waitIdle();

    // R3 other variants, branch with positive displacement
    expectWord(mk(6'h3E, 3, 5, 6, 0, 9, 31), "R3 R5 R6 params slots 2,3");
    sendWord(mk(6'h3E, 3, 5, 6, 0, 9, 31));
    waitIdle();
    expectWord(mk(6'h3F, 7, 8, 1, 0, 9, 20), "R3 R5 four slots param slot 2");
    sendWord(mk(6'h3F, 7, 8, 1, 0, 9, 20));
    waitIdle();

    // R12 s bit ignored
    expectWord(mk(6'h3D, 2, 3, 4, 0, 11, 12), "R12 s bit clear");
    sendWord(mk(6'h3D, 2, 3, 4, 0, 11, 12));
    waitIdle();
    expectWord(mk(6'h3D, 2, 3, 4, 0, 11, 12), "R12 s bit set gives same items");
    sendWord(mk(6'h3D, 2, 3, 4, 1, 11, 12));
    waitIdle();

    // R8 loosely packed
    expectWord(32'hC4A5_0003, "R8 loose with extra entry");
    sendWord(32'hC4A5_0003);
    waitIdle();
    expectWord(32'hEC00_0000, "R8 loose index 0 no extra");
    sendWord(32'hEC00_0000);
    waitIdle();

    // R10 back to back words
    expectWord(mk(6'h3C, 1, 2, 0, 0, 0, 0), "R10 back to back first");
    expectWord(32'h0BAD_CAFE, "R10 back to back second");
    sendWord(mk(6'h3C, 1, 2, 0, 0, 0, 0));
    sendWord(32'h0BAD_CAFE);
    waitIdle();

    // R11 taken branch flushes remaining slots
    pushExp(slotOut(5'd5, 0, 0), "R11 branch slot issues");
    sendWord(mk(6'h3C, 5, 1, 2, 0, 0, 0));
    branchTaken = 1'b1;
    @(negedge clk);
    check(!fetchStall && nextReady, "R11 stall drops on taken branch",
          {30'd0, fetchStall, nextReady}, 32'h1);
    @(posedge clk); #1;
    branchTaken = 1'b0;
    @(negedge clk);
    check(!issueValid, "R11 remaining slots flushed", {31'd0, issueValid}, 32'h0);
    waitIdle();

    // R9 window select
    winWrEn = 1; winWrData = 2'd2;
    @(posedge clk); #1;
    winWrEn = 0;
    mWin = 2'd2;
    expectWord(mk(6'h3D, 1, 0, 2, 0, 4, 5'b10000), "R9 window 2 reads");
    sendWord(mk(6'h3D, 1, 0, 2, 0, 4, 5'b10000));
    waitIdle();

    check(expQ.size() == 0, "R3 scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule